// File: doc/BRIEF.md
# ARINC 429 Transmit Arbiter and Serializer

This block takes 32-bit words from four producers and sends them one at a time as a return-to-zero, three-level serial stream. The four producers are an urgent register, a scheduler port, a background register and a transmit FIFO. Whenever the line is free, a fixed priority order picks the next producer. A control input can swap that order so the FIFO comes first. The producer that wins gets a single-cycle accept pulse in the same cycle its word is captured. Each producer keeps its valid asserted until it sees that pulse.

The word is sent with the eight label bits first, most significant of them first. The remaining bits follow from bit 8 up to bit 31. Bit 31 carries parity, which can be odd, even, or the bit as supplied. Each bit lasts one bit period. For the first half of the period, one of two drive outputs is high: the HI output for a one, the LO output for a zero. For the second half, both outputs are low, which is the NULL level. Four NULL bit times follow every word. The rate select and the parity mode are captured with the word. The FIFO can be paced: in paced mode it is only eligible after an interval tick, and that tick comes from a programmable cycle counter.

Top module: `a429_tx_core`

## Requirements
- R1: With `fifo_first`=0, a free transmitter takes the highest-ranked valid source in the order urgent (index 0), scheduler (1), background (2), FIFO (3).
- R2: With `fifo_first`=1, the order becomes FIFO, scheduler, background, urgent.
- R3: A word is taken only in a cycle where `busy` is 0. A source that becomes valid during a word is taken in the first idle cycle after that word and its gap have finished.
- R4: The accept to the chosen source is high for exactly one cycle, in the cycle the word is captured. At most one accept is high in any cycle.
- R5: Serial order is word bits 7,6,…,0, then 8,9,…,31. The first bit is driven in the cycle after the accept.
- R6: `parity_mode` 2'b01 sets bit 31 so the word has an odd number of ones. 2'b10 sets it so the count is even. 2'b00 and 2'b11 send the supplied bit 31 unchanged.
- R7: A bit lasts 2×`HS_HALF_CYCLES` clocks when the rate select is 0, and 16×`HS_HALF_CYCLES` clocks when it is 1. In the first half of the bit, `line_hi` is high for a one or `line_lo` is high for a zero. In the second half, both are low. The two outputs are never high together.
- R8: Four bit times with both outputs low follow the last bit of every word before `busy` falls.
- R9: The rate select and the parity mode are captured with the word. Changing them while a word is being sent does not alter that word.
- R10: With `fifo_paced`=1, a tick occurs every `pace_interval`+1 cycles and grants one FIFO credit, visible from the next cycle. The FIFO is eligible only while a credit is held. At most one credit is held at a time, and it is used up when the FIFO is accepted. With `fifo_paced`=0, the counter and the credit are cleared.
- R11: After reset, `busy`, `line_hi` and `line_lo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| urg_valid | input | 1 | Urgent register holds a word |
| urg_word | input | 32 | Urgent word |
| urg_accept | output | 1 | Urgent word taken |
| sch_valid | input | 1 | Scheduler offers a word |
| sch_word | input | 32 | Scheduler word |
| sch_accept | output | 1 | Scheduler word taken |
| bg_valid | input | 1 | Background register holds a word |
| bg_word | input | 32 | Background word |
| bg_accept | output | 1 | Background word taken |
| fifo_valid | input | 1 | FIFO not empty |
| fifo_word | input | 32 | FIFO head word |
| fifo_accept | output | 1 | FIFO head taken |
| fifo_first | input | 1 | Swap the priority order |
| fifo_paced | input | 1 | Release FIFO words only on interval ticks |
| pace_interval | input | 16 | Tick spacing minus one, in clocks |
| rate_low | input | 1 | 0 selects the fast rate, 1 the slow rate |
| parity_mode | input | 2 | Parity selection as in R6 |
| busy | output | 1 | A word or its gap is in progress |
| line_hi | output | 1 | Drive the line to the HI level |
| line_lo | output | 1 | Drive the line to the LO level |

## Verification
An arbiter fault shows up as an accept pulse on the wrong source in the very first idle cycle. That cycle comes at most one word plus gap after the stimulus. A permutation or parity fault corrupts the drive outputs in the half-bit where the affected bit is sent, so it appears within 32 bit times. A fault in the timing counters moves an edge on `line_hi`, `line_lo` or `busy` within one bit period. A pacing fault moves the FIFO accept away from the cycle that follows the tick.

// File: rtl/a429_tx_pkg.sv
// Package: shared constants, types and word-shaping functions for the
// ARINC 429 transmit path. Assumes a 32-bit word with the label in bits 7..0.
package a429_tx_pkg;

    localparam int WORD_W    = 32;
    localparam int LABEL_W   = 8;
    localparam int NUM_SRC   = 4;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int GAP_BITS  = 4;
    localparam int SLOW_MULT = 8;

    typedef enum logic [1:0] {
        PAR_PASS  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_PASS2 = 2'b11
    } par_mode_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_URG  = 2'd0,
        SRC_SCH  = 2'd1,
        SRC_BG   = 2'd2,
        SRC_FIFO = 2'd3
    } src_t;

    // Replace bit 31 according to the parity mode.
    function automatic logic [WORD_W-1:0] fix_parity(logic [WORD_W-1:0] w, par_mode_t m);
        logic [WORD_W-1:0] r;
        r = w;
        case (m)
            PAR_ODD:  r[WORD_W-1] = ~(^w[WORD_W-2:0]);
            PAR_EVEN: r[WORD_W-1] =  (^w[WORD_W-2:0]);
            default:  r[WORD_W-1] = w[WORD_W-1];
        endcase
        return r;
    endfunction

    // Reorder so that serial slot k sits at position k: label reversed, rest ascending.
    function automatic logic [WORD_W-1:0] serial_order(logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] s;
        for (int k = 0; k < WORD_W; k++) begin
            if (k < LABEL_W) s[k] = w[LABEL_W-1-k];
            else             s[k] = w[k];
        end
        return s;
    endfunction

    // Map a priority rank to a source index; the swapped order puts the FIFO first.
    function automatic src_t rank_src(int rank, logic swap);
        src_t s;
        if (!swap) begin
            case (rank)
                0:       s = SRC_URG;
                1:       s = SRC_SCH;
                2:       s = SRC_BG;
                default: s = SRC_FIFO;
            endcase
        end else begin
            case (rank)
                0:       s = SRC_FIFO;
                1:       s = SRC_SCH;
                2:       s = SRC_BG;
                default: s = SRC_URG;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/a429_tx_pacer.sv
// Module: FIFO pacing credit. A free-running counter ticks every
// (interval+1) clocks while pacing is on; a tick leaves one credit, and a
// FIFO accept consumes it. Assumes interval is held stable while pacing.
module a429_tx_pacer #(
    parameter int PACE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paced_en,
    input  logic [PACE_W-1:0] interval,
    input  logic              consume,
    output logic              credit
);

    logic [PACE_W-1:0] cnt_q;
    logic              tick;

    assign tick = paced_en && (cnt_q == interval);

    // Interval counter: wraps on tick, held at zero when pacing is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !paced_en) cnt_q <= '0;
        else if (tick)           cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // Credit flag: a tick sets it (and wins over consume), an accept clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || !paced_en) credit <= 1'b0;
        else if (tick)           credit <= 1'b1;
        else if (consume)        credit <= 1'b0;
    end

    // R10: a tick always leaves a credit behind on the next cycle.
    a_r10_tick_gives_credit: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (credit || !paced_en));

endmodule

// File: rtl/a429_tx_arbiter.sv
// Module: fixed-order selector across the word sources. The rank order is
// chosen by 'swap'; a grant is issued only while the serializer is ready.
// Assumes requests are already qualified (FIFO pacing applied upstream).
module a429_tx_arbiter
    import a429_tx_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         swap,
    input  logic         ready,
    output logic [N-1:0] accept,
    output src_t         sel
);

    logic hit;

    // Scan ranks from lowest to highest so the best-ranked request wins last.
    always_comb begin
        sel = SRC_URG;
        hit = 1'b0;
        for (int r = N - 1; r >= 0; r--) begin
            if (req[rank_src(r, swap)]) begin
                sel = rank_src(r, swap);
                hit = 1'b1;
            end
        end
    end

    // One-hot accept toward the chosen source when the line is free.
    always_comb begin
        accept = '0;
        if (ready && hit) accept[sel] = 1'b1;
    end

    // R1: in the default order, a waiting urgent word always wins a free line.
    a_r1_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req[SRC_URG] && !swap) |-> accept[SRC_URG]);

    // R2: in the swapped order, a waiting FIFO word always wins a free line.
    a_r2_fifo_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req[SRC_FIFO] && swap) |-> accept[SRC_FIFO]);

endmodule

// File: rtl/a429_tx_shifter.sv
// Module: serializer. Captures a word with its parity and rate, then emits
// 32 return-to-zero bits (label first) followed by a NULL gap. Assumes a load
// is presented only while busy is low.
module a429_tx_shifter
    import a429_tx_pkg::*;
#(
    parameter int HS_HALF = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              slow_in,
    input  par_mode_t         pmode_in,
    output logic              busy,
    output logic              line_hi,
    output logic              line_lo
);

    localparam int HALF_MAX = HS_HALF * SLOW_MULT;
    localparam int CW       = $clog2(HALF_MAX + 1);
    localparam int TOTAL    = WORD_W + GAP_BITS;
    localparam int BW       = $clog2(TOTAL + 1);

    logic [WORD_W-1:0] sh_q;
    logic              slow_q;
    logic [CW-1:0]     hcnt_q;
    logic              second_q;
    logic [BW-1:0]     bit_q;
    logic [CW-1:0]     half_len;
    logic              half_end;
    logic              in_data;

    assign half_len = slow_q ? CW'(HALF_MAX) : CW'(HS_HALF);
    assign half_end = (hcnt_q == half_len - 1'b1);
    assign in_data  = busy && (bit_q < BW'(WORD_W)) && !second_q;
    assign line_hi  = in_data &&  sh_q[0];
    assign line_lo  = in_data && !sh_q[0];

    // Sequencing: load captures the shaped word, then count halves and bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sh_q     <= '0;
            slow_q   <= 1'b0;
            hcnt_q   <= '0;
            second_q <= 1'b0;
            bit_q    <= '0;
        end else if (!busy) begin
            if (load) begin
                busy     <= 1'b1;
                sh_q     <= serial_order(fix_parity(word_in, pmode_in));
                slow_q   <= slow_in;
                hcnt_q   <= '0;
                second_q <= 1'b0;
                bit_q    <= '0;
            end
        end else if (!half_end) begin
            hcnt_q <= hcnt_q + 1'b1;
        end else begin
            hcnt_q <= '0;
            if (!second_q) begin
                second_q <= 1'b1;
            end else begin
                second_q <= 1'b0;
                if (bit_q < BW'(WORD_W)) sh_q <= sh_q >> 1;
                if (bit_q == BW'(TOTAL - 1)) busy <= 1'b0;
                else                         bit_q <= bit_q + 1'b1;
            end
        end
    end

    // R7: the two drive outputs are never both high.
    a_r7_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    // R5: the first serial bit is word bit 7 (label MSB), right after the load.
    a_r5_label_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (line_hi == $past(word_in[LABEL_W-1])) &&
                            (line_lo == !$past(word_in[LABEL_W-1])));

endmodule

// File: rtl/a429_tx_core.sv
// Module: top of the transmit path. Qualifies the FIFO request with the
// pacing credit, arbitrates the four sources and feeds the serializer.
// Assumes each source holds its valid and word stable until accepted.
module a429_tx_core
    import a429_tx_pkg::*;
#(
    parameter int HS_HALF_CYCLES = 250,
    parameter int PACE_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              urg_valid,
    input  logic [31:0]       urg_word,
    output logic              urg_accept,
    input  logic              sch_valid,
    input  logic [31:0]       sch_word,
    output logic              sch_accept,
    input  logic              bg_valid,
    input  logic [31:0]       bg_word,
    output logic              bg_accept,
    input  logic              fifo_valid,
    input  logic [31:0]       fifo_word,
    output logic              fifo_accept,
    input  logic              fifo_first,
    input  logic              fifo_paced,
    input  logic [PACE_W-1:0] pace_interval,
    input  logic              rate_low,
    input  logic [1:0]        parity_mode,
    output logic              busy,
    output logic              line_hi,
    output logic              line_lo
);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] acc;
    logic               credit;
    logic               load;
    src_t               sel;
    logic [WORD_W-1:0]  words [NUM_SRC];
    logic [WORD_W-1:0]  chosen;

    assign words[SRC_URG]  = urg_word;
    assign words[SRC_SCH]  = sch_word;
    assign words[SRC_BG]   = bg_word;
    assign words[SRC_FIFO] = fifo_word;

    // Request vector; the FIFO needs a credit when paced.
    always_comb begin
        req           = '0;
        req[SRC_URG]  = urg_valid;
        req[SRC_SCH]  = sch_valid;
        req[SRC_BG]   = bg_valid;
        req[SRC_FIFO] = fifo_valid && (!fifo_paced || credit);
    end

    assign urg_accept  = acc[SRC_URG];
    assign sch_accept  = acc[SRC_SCH];
    assign bg_accept   = acc[SRC_BG];
    assign fifo_accept = acc[SRC_FIFO];
    assign load        = |acc;
    assign chosen      = words[sel];

    a429_tx_pacer #(.PACE_W(PACE_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .paced_en (fifo_paced),
        .interval (pace_interval),
        .consume  (acc[SRC_FIFO]),
        .credit   (credit)
    );

    a429_tx_arbiter #(.N(NUM_SRC)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .swap   (fifo_first),
        .ready  (!busy),
        .accept (acc),
        .sel    (sel)
    );

    a429_tx_shifter #(.HS_HALF(HS_HALF_CYCLES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_in  (chosen),
        .slow_in  (rate_low),
        .pmode_in (par_mode_t'(parity_mode)),
        .busy     (busy),
        .line_hi  (line_hi),
        .line_lo  (line_lo)
    );

    // R3: nothing is accepted while a word or its gap is in progress.
    a_r3_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R4: at most one accept, and a taken word makes the serializer busy.
    a_r4_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc));
    a_r4_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !load));

    // R10: a paced FIFO word is only taken while a credit is held.
    a_r10_paced_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_paced && fifo_accept) |-> credit);

endmodule

// File: tb/sim_a429_tx_core.sv
module sim_a429_tx_core;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int WORD_CYC_F = 36 * 2 * HALF;
    localparam int WORD_CYC_S = 36 * 2 * HALF * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  v = '0;
    logic [31:0] w [4];
    logic        fifo_first = 1'b0, fifo_paced = 1'b0, rate_low = 1'b0;
    logic [15:0] pace_interval = 16'd0;
    logic [1:0]  parity_mode = 2'b01;
    logic        urg_accept, sch_accept, bg_accept, fifo_accept;
    logic        busy, line_hi, line_lo;
    logic [3:0]  acc;

    int n_vec = 0, n_fail = 0, cyc = 0;
    bit running = 0;
    bit          q_hi [$];
    bit          q_lo [$];
    int          q_tag [$];
    int          glog [$];
    int          gcyc [$];
    int          mcnt = 0;
    bit          mcredit = 0;
    int          busy_cnt = 0;

    assign acc = {fifo_accept, bg_accept, sch_accept, urg_accept};

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        w[0] = '0; w[1] = '0; w[2] = '0; w[3] = '0;
    end

    a429_tx_core #(.HS_HALF_CYCLES(HALF), .PACE_W(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .urg_valid(v[0]), .urg_word(w[0]), .urg_accept(urg_accept),
        .sch_valid(v[1]), .sch_word(w[1]), .sch_accept(sch_accept),
        .bg_valid(v[2]), .bg_word(w[2]), .bg_accept(bg_accept),
        .fifo_valid(v[3]), .fifo_word(w[3]), .fifo_accept(fifo_accept),
        .fifo_first(fifo_first), .fifo_paced(fifo_paced),
        .pace_interval(pace_interval), .rate_low(rate_low),
        .parity_mode(parity_mode), .busy(busy),
        .line_hi(line_hi), .line_lo(line_lo)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Build the expected line symbols of one word (R5 order, R6 parity, R7 halves, R8 gap).
    task automatic build(logic [31:0] d, bit slow, logic [1:0] pm);
        int h;
        int ones;
        bit b;
        h = slow ? HALF * 8 : HALF;
        ones = 0;
        for (int i = 0; i < 31; i++) ones += d[i];
        if (pm == 2'b01) d[31] = (ones % 2 == 0);
        else if (pm == 2'b10) d[31] = (ones % 2 == 1);
        for (int k = 0; k < 32; k++) begin
            b = (k < 8) ? d[7 - k] : d[k];
            for (int c = 0; c < h; c++) begin
                q_hi.push_back(b); q_lo.push_back(!b); q_tag.push_back(k == 31 ? 6 : 5);
            end
            for (int c = 0; c < h; c++) begin
                q_hi.push_back(0); q_lo.push_back(0); q_tag.push_back(7);
            end
        end
        for (int c = 0; c < 4 * 2 * h; c++) begin
            q_hi.push_back(0); q_lo.push_back(0); q_tag.push_back(8);
        end
    endtask

    // Reference model, compared on every falling edge.
    always @(negedge clk) begin
        if (rst_n && running) begin
            cyc++;
            if (busy) busy_cnt++;
            if (q_hi.size() > 0) begin
                bit eh, el; int t;
                eh = q_hi.pop_front(); el = q_lo.pop_front(); t = q_tag.pop_front();
                chk({line_hi, line_lo} == {eh, el}, $sformatf("R%0d", t), "line", {line_hi, line_lo}, {eh, el});
                chk(busy == 1'b1, "R3", "busy during word", busy, 1);
                chk(acc == 4'b0, "R3", "accept while busy", acc, 0);
            end else begin
                int pick;
                bit [3:0] rq;
                bit [3:0] exp_acc;
                chk({line_hi, line_lo} == 2'b00, "R8", "idle line", {line_hi, line_lo}, 0);
                chk(busy == 1'b0, "R8", "busy after gap", busy, 0);
                rq = v;
                rq[3] = v[3] && (!fifo_paced || mcredit);
                pick = -1;
                for (int r = 3; r >= 0; r--) begin
                    int s;
                    if (!fifo_first) s = r;
                    else s = (r == 0) ? 3 : (r == 3) ? 0 : r;
                    if (rq[s]) pick = s;
                end
                exp_acc = (pick >= 0) ? (4'b1 << pick) : 4'b0;
                chk(acc == exp_acc, (fifo_paced && (acc[3] || exp_acc[3])) ? "R10" :
                    (fifo_first ? "R2" : "R1"), "accept vector", acc, exp_acc);
                if (pick >= 0) begin
                    glog.push_back(pick);
                    gcyc.push_back(cyc);
                    build(w[pick], rate_low, parity_mode);
                end
            end
            // Pacing credit model (R10).
            if (!fifo_paced) begin
                mcnt = 0; mcredit = 0;
            end else if (mcnt == int'(pace_interval)) begin
                mcnt = 0; mcredit = 1;
            end else begin
                mcnt++;
                if (acc[3]) mcredit = 0;
            end
        end
    end

    task automatic send(int s, logic [31:0] d);
        @(posedge clk); #1;
        w[s] = d; v[s] = 1'b1;
        do @(negedge clk); while (!acc[s]);
        @(posedge clk); #1;
        v[s] = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #2; end while (q_hi.size() != 0 || v != 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_log(string req, int e0, int e1, int e2, int e3, int n);
        int e [4];
        e = '{e0, e1, e2, e3};
        chk(glog.size() == n, req, "grant count", glog.size(), n);
        for (int i = 0; i < n && i < glog.size(); i++)
            chk(glog[i] == e[i], req, $sformatf("grant %0d source", i), glog[i], e[i]);
        glog.delete();
        gcyc.delete();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        int t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state.
        chk({busy, line_hi, line_lo} == 3'b000, "R11", "reset outputs", {busy, line_hi, line_lo}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1; running = 1;

        // Single urgent word, odd parity, fast rate (R5, R6, R7).
        send(0, 32'h1234_5678);
        wait_idle();
        check_log("R1", 0, 0, 0, 0, 1);

        // R1: all four at once, default order.
        fork
            send(0, 32'hA5A5_0F0F);
            send(1, 32'h0000_00FF);
            send(2, 32'h8000_0001);
            send(3, 32'h7654_3210);
        join
        wait_idle();
        check_log("R1", 0, 1, 2, 3, 4);

        // R2: swapped order.
        fifo_first = 1'b1;
        fork
            send(0, 32'h1111_1111);
            send(1, 32'h2222_2222);
            send(2, 32'h3333_3333);
            send(3, 32'h4444_4444);
        join
        wait_idle();
        check_log("R2", 3, 1, 2, 0, 4);
        fifo_first = 1'b0;

        // R3: urgent raised mid-word waits for the word, then overtakes background.
        fork
            send(1, 32'hDEAD_BEEF);
            begin
                repeat (20) @(posedge clk);
                fork
                    send(2, 32'h0BAD_F00D);
                    send(0, 32'hC0FF_EE00);
                join
            end
        join
        wait_idle();
        check_log("R3", 1, 0, 2, 0, 3);

        // R6: even parity and both pass-through codes.
        parity_mode = 2'b10; send(2, 32'h0000_0003); wait_idle();
        parity_mode = 2'b00; send(2, 32'h8000_0001); wait_idle();
        parity_mode = 2'b11; send(2, 32'h7FFF_FFFF); wait_idle();
        check_log("R6", 2, 2, 2, 0, 3);

        // R9: slow word, rate and parity changed while it is sent.
        parity_mode = 2'b01; rate_low = 1'b1;
        busy_cnt = 0;
        fork
            send(3, 32'h00C3_5A81);
            begin
                repeat (60) @(posedge clk); #1;
                rate_low = 1'b0; parity_mode = 2'b10;
            end
        join
        wait_idle();
        chk(busy_cnt == WORD_CYC_S, "R9", "slow word length", busy_cnt, WORD_CYC_S);
        busy_cnt = 0;
        send(1, 32'h0F0F_F0F0);
        wait_idle();
        chk(busy_cnt == WORD_CYC_F, "R7", "fast word length", busy_cnt, WORD_CYC_F);
        check_log("R9", 3, 1, 0, 0, 2);

        // R10: paced FIFO waits for the tick, then for the next one.
        parity_mode = 2'b01;
        pace_interval = 16'd40;
        @(posedge clk); #1;
        fifo_paced = 1'b1;
        w[3] = 32'h5555_AAAA; v[3] = 1'b1;
        @(negedge clk); #1;
        t0 = cyc;
        do @(negedge clk); while (!acc[3]);
        @(posedge clk); #1; v[3] = 1'b0;
        chk(gcyc.size() == 1 && gcyc[0] == t0 + 41, "R10", "first paced grant cycle",
            gcyc.size() > 0 ? gcyc[0] : -1, t0 + 41);
        send(3, 32'h0102_0304);
        wait_idle();
        check_log("R10", 3, 3, 0, 0, 2);
        fifo_paced = 1'b0;

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule